// File: doc/BRIEF.md
# Fractional Microsecond Tick Generator

This block turns a fast reference clock into a one-cycle enable pulse that arrives, on long-term average, once per microsecond. The rate is set by a ratio of two small integers held in a configuration register: every reference cycle the numerator is added to an accumulator, and every time the accumulator reaches the denominator one pulse is issued and the denominator is taken away. References that are not a whole multiple of 1 MHz, such as 19.2 MHz (5/96), therefore keep an exact average with no drift.

Each pulse advances a free-running up-counter that wraps at its full width. A small register port reads the counter, reads and writes the ratio, and reads and writes a freeze bit that stops both the counter and the accumulator. The pulse is also brought out so that other timers in the same clock domain can use it as a count enable.

Top module: `tick_us_gen`

## Requirements
- R1: After a synchronous active-low reset the counter reads 0, the ratio register reads 0x0000000b (1/12), the freeze register reads 0 and `tick_o` is low.
- R2: The ratio register holds the numerator minus one in bits [15:8] and the denominator minus one in bits [7:0]. With numerator D not above denominator M, after k counting cycles that follow a reset or ratio write, the counter has advanced by floor(k*D/M).
- R3: `tick_o` is high for exactly the cycles that follow a clock edge at which the counter advanced, and the counter advances by exactly one per pulse.
- R4: The counter wraps from all ones to zero and keeps counting.
- R5: While freeze register bit 0 is 1, the counter and accumulator hold and no pulse is issued; clearing the bit resumes with the stored remainder kept.
- R6: A write to the ratio register clears the accumulator; the edge of that write issues no pulse and does not move the counter.
- R7: When the numerator is equal to or larger than the denominator, a pulse is issued after every counting cycle.
- R8: Register reads are combinational: offset 0x10 returns the counter, 0x14 returns the ratio in bits [15:0] with zeros above, 0x4c returns the freeze bit in bit 0; any other offset returns 0. Writes to 0x10, to unmapped offsets, and to the bits above the defined fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | ADDR_W (8) | Register byte offset |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for the addressed register |
| tick_o | output | 1 | One-cycle microsecond enable pulse |

## Verification
The bound checker watches every cycle that the accumulator stays below the denominator, that the counter moves only with a pulse and by one, that freeze and ratio writes stop pulses and hold or clear the remainder, and that a full-rate ratio pulses every cycle. Whether the long-run pulse count equals floor(k*D/M), whether a resumed count keeps its remainder across a freeze, and whether the address decode and ignored writes behave only show up in the bench's sweeps over many ratios, which compute the expected count arithmetically and read it back through the register port.

// File: rtl/tick_us_pkg.sv
// Package: shared constants and the ratio register layout for the
// microsecond tick generator. Assumes byte offsets fit in 8 bits.
package tick_us_pkg;

    localparam int unsigned FRAC_W = 8;

    localparam int unsigned OFS_COUNT  = 'h10;
    localparam int unsigned OFS_RATIO  = 'h14;
    localparam int unsigned OFS_FREEZE = 'h4c;

    // Ratio register: numerator minus one above, denominator minus one below.
    typedef struct packed {
        logic [FRAC_W-1:0] num_m1;
        logic [FRAC_W-1:0] den_m1;
    } ratio_cfg_t;

    localparam ratio_cfg_t RATIO_RESET = '{num_m1: 8'h00, den_m1: 8'h0b};

endpackage

// File: rtl/tick_frac_accum.sv
// Fractional rate accumulator. Adds the numerator each running cycle and
// issues one step when the sum reaches the denominator. Assumes the
// caller drops run_i during clear_i. A ratio at or above one steps every
// running cycle with the remainder held at zero.
module tick_frac_accum #(
    parameter int unsigned FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic [FRAC_W-1:0] num_m1_i,
    input  logic [FRAC_W-1:0] den_m1_i,
    output logic              step_o,
    output logic              tick_o,
    output logic [FRAC_W-1:0] acc_o
);

    localparam int unsigned SUM_W = FRAC_W + 2;

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_nxt;
    logic [SUM_W-1:0]  num_full;
    logic [SUM_W-1:0]  den_full;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  diff;
    logic              ratio_full;
    logic              reach;
    logic              tick_q;

    assign num_full   = SUM_W'(num_m1_i) + SUM_W'(1);
    assign den_full   = SUM_W'(den_m1_i) + SUM_W'(1);
    assign sum        = SUM_W'(acc_q) + num_full;
    assign diff       = sum - den_full;
    assign ratio_full = (num_full >= den_full);
    assign reach      = (sum >= den_full);
    assign step_o     = run_i && (ratio_full || reach);

    // Next remainder: cleared, held, wrapped or grown.
    always_comb begin
        if (clear_i) begin
            acc_nxt = '0;
        end else if (!run_i) begin
            acc_nxt = acc_q;
        end else if (ratio_full) begin
            acc_nxt = '0;
        end else if (reach) begin
            acc_nxt = diff[FRAC_W-1:0];
        end else begin
            acc_nxt = sum[FRAC_W-1:0];
        end
    end

    // Remainder and pulse registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= acc_nxt;
            tick_q <= step_o;
        end
    end

    assign tick_o = tick_q;
    assign acc_o  = acc_q;

endmodule

// File: rtl/tick_us_counter.sv
// Free-running wrapping up-counter advanced by a one-cycle increment.
// Assumes inc_i is already qualified by freeze and ratio writes.
module tick_us_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] count_q;

    // Count register, wraps naturally at full width.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/tick_us_regs.sv
// Register port: ratio and freeze storage, write decode and a
// combinational read mux. Assumes DATA_W is at least 16.
module tick_us_regs
    import tick_us_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output ratio_cfg_t        ratio_o,
    output logic              freeze_o,
    output logic              ratio_wr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned RATIO_W = $bits(ratio_cfg_t);

    logic              hit_count;
    logic              hit_ratio;
    logic              hit_freeze;
    ratio_cfg_t        ratio_q;
    logic              freeze_q;
    logic [DATA_W-1:0] count_ext;

    assign hit_count  = (addr_i == ADDR_W'(OFS_COUNT));
    assign hit_ratio  = (addr_i == ADDR_W'(OFS_RATIO));
    assign hit_freeze = (addr_i == ADDR_W'(OFS_FREEZE));
    assign ratio_wr_o = wr_i && hit_ratio;

    // Fit the counter to the data bus width.
    generate
        if (CNT_W >= DATA_W) begin : g_cnt_trunc
            assign count_ext = count_i[DATA_W-1:0];
        end else begin : g_cnt_pad
            assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count_i};
        end
    endgenerate

    // Writable storage for the ratio and the freeze bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ratio_q  <= RATIO_RESET;
            freeze_q <= 1'b0;
        end else if (wr_i) begin
            if (hit_ratio) begin
                ratio_q <= ratio_cfg_t'(wdata_i[RATIO_W-1:0]);
            end
            if (hit_freeze) begin
                freeze_q <= wdata_i[0];
            end
        end
    end

    // Read mux, unmapped offsets read as zero.
    always_comb begin
        rdata_o = '0;
        if (hit_count) begin
            rdata_o = count_ext;
        end else if (hit_ratio) begin
            rdata_o[RATIO_W-1:0] = ratio_q;
        end else if (hit_freeze) begin
            rdata_o[0] = freeze_q;
        end
    end

    assign ratio_o  = ratio_q;
    assign freeze_o = freeze_q;

endmodule

// File: rtl/tick_us_gen.sv
// Top of the microsecond tick generator: register port, fractional
// accumulator and counter. Assumes a single reference clock domain.
module tick_us_gen
    import tick_us_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              tick_o
);

    ratio_cfg_t        ratio;
    logic              freeze;
    logic              ratio_wr;
    logic              run;
    logic              step;
    logic [FRAC_W-1:0] acc_val;
    logic [CNT_W-1:0]  count_val;

    assign run = !freeze && !ratio_wr;

    tick_us_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .count_i    (count_val),
        .ratio_o    (ratio),
        .freeze_o   (freeze),
        .ratio_wr_o (ratio_wr),
        .rdata_o    (bus_rdata_o)
    );

    tick_frac_accum #(
        .FRAC_W (FRAC_W)
    ) u_accum (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run),
        .clear_i  (ratio_wr),
        .num_m1_i (ratio.num_m1),
        .den_m1_i (ratio.den_m1),
        .step_o   (step),
        .tick_o   (tick_o),
        .acc_o    (acc_val)
    );

    tick_us_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (step),
        .count_o (count_val)
    );

endmodule

// File: rtl/tick_us_gen_chk.sv
// Checker for the microsecond tick generator, bound to the top module.
module tick_us_gen_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [15:0]      ratio_i,
    input logic [7:0]       acc_i,
    input logic [CNT_W-1:0] count_i,
    input logic             freeze_i,
    input logic             ratio_wr_i,
    input logic             tick_i
);

    AST_ACC_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_i <= ratio_i[7:0]); // R2

    AST_TICK_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |-> count_i == CNT_W'($past(count_i) + CNT_W'(1))); // R3

    AST_COUNT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |-> $stable(count_i)); // R3

    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(count_i) == '1 && tick_i) |-> count_i == '0); // R4

    AST_FROZEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(freeze_i) |-> !tick_i); // R5

    AST_FROZEN_REMAINDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(freeze_i) && !$past(ratio_wr_i)) |-> $stable(acc_i)); // R5

    AST_RATIO_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ratio_wr_i) |-> (acc_i == '0 && !tick_i)); // R6

    AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(ratio_i[15:8] >= ratio_i[7:0] && !freeze_i && !ratio_wr_i) |-> tick_i); // R7

endmodule

bind tick_us_gen tick_us_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_i    (ratio),
    .acc_i      (acc_val),
    .count_i    (count_val),
    .freeze_i   (freeze),
    .ratio_wr_i (ratio_wr),
    .tick_i     (tick_o)
);

// File: tb/sim_tick_us_gen.sv
module sim_tick_us_gen;

    localparam int CW   = 10;
    localparam int WRAP = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        tick;

    int checks = 0;
    int errors = 0;
    int ticks_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_us_gen #(.CNT_W(CW), .DATA_W(32), .ADDR_W(8)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tick_o      (tick)
    );

    always @(negedge clk) if (rst_n && tick) ticks_seen++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
        #1;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a; wr = 1'b0;
        #1;
        d = rdata;
    endtask

    function automatic int expect_adv(input int k, input int d, input int m);
        return (d >= m) ? k : (k * d) / m;
    endfunction

    initial begin
        logic [31:0] v;
        int base;
        int t0;
        rst_n = 1'b0; wr = 1'b0; addr = 8'h00; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        rd_reg(8'h10, v); chk("R1 count", v, 32'h0);
        rd_reg(8'h14, v); chk("R1 ratio", v, 32'h0000000b);
        rd_reg(8'h4c, v); chk("R1 freeze", v, 32'h0);
        chk("R1 tick", {31'b0, tick}, 32'h0);

        // R2 default 1/12 from reset
        step(120);
        rd_reg(8'h10, v); chk("R2 default ratio", v, 32'd10);

        // R2 R7 R3 sweep of numerators and denominators
        for (int d = 1; d <= 6; d++) begin
            for (int m = 1; m <= 10; m++) begin
                rd_reg(8'h10, v); base = int'(v);
                wr_reg(8'h14, {16'h0, 8'(d - 1), 8'(m - 1)});
                t0 = ticks_seen;
                for (int k = 1; k <= 24; k++) begin
                    step(1);
                    rd_reg(8'h10, v);
                    chk(d >= m ? "R7 full rate" : "R2 ratio sweep", v,
                        32'((base + expect_adv(k, d, m)) % WRAP));
                end
                chk("R3 pulses match count", 32'(ticks_seen - t0), 32'(expect_adv(24, d, m)));
            end
        end

        // R6 ratio write clears the remainder
        rd_reg(8'h10, v); base = int'(v);
        wr_reg(8'h14, 32'h0000000b);
        step(11);
        rd_reg(8'h10, v); chk("R6 before rewrite", v, 32'(base));
        wr_reg(8'h14, 32'h0000000b);
        step(11);
        rd_reg(8'h10, v); chk("R6 remainder cleared", v, 32'(base));
        step(1);
        rd_reg(8'h10, v); chk("R6 first pulse", v, 32'((base + 1) % WRAP));

        // R5 freeze keeps the remainder, 5/96
        rd_reg(8'h10, v); base = int'(v);
        wr_reg(8'h14, 32'h0000045f);
        step(50);
        wr_reg(8'h4c, 32'h1);
        rd_reg(8'h4c, v); chk("R5 freeze reads", v, 32'h1);
        rd_reg(8'h10, v); chk("R5 before hold", v, 32'((base + expect_adv(51, 5, 96)) % WRAP));
        t0 = ticks_seen;
        step(100);
        rd_reg(8'h10, v); chk("R5 held", v, 32'((base + expect_adv(51, 5, 96)) % WRAP));
        chk("R5 no pulses", 32'(ticks_seen - t0), 32'h0);

        // R8 ignored writes while frozen
        wr_reg(8'h10, 32'h00000155);
        rd_reg(8'h10, v); chk("R8 count write ignored", v, 32'((base + expect_adv(51, 5, 96)) % WRAP));
        wr_reg(8'h20, 32'hffffffff);
        rd_reg(8'h20, v); chk("R8 unmapped reads zero", v, 32'h0);
        rd_reg(8'h18, v); chk("R8 unmapped 0x18", v, 32'h0);
        wr_reg(8'h14, 32'habcd045f);
        rd_reg(8'h14, v); chk("R8 ratio upper bits", v, 32'h0000045f);

        // R5 resume: the ratio rewrite above restarted the remainder
        rd_reg(8'h10, v); base = int'(v);
        wr_reg(8'h4c, 32'hfffffffe);
        rd_reg(8'h4c, v); chk("R8 freeze upper bits", v, 32'h0);
        step(40);
        wr_reg(8'h4c, 32'h1);
        step(30);
        wr_reg(8'h4c, 32'h0);
        for (int k = 1; k <= 150; k++) begin
            step(1);
            rd_reg(8'h10, v);
            chk("R5 resume", v, 32'((base + expect_adv(41 + k, 5, 96)) % WRAP));
        end

        // R4 wrap at full rate
        wr_reg(8'h14, 32'h00000000);
        rd_reg(8'h10, v); base = int'(v);
        step(WRAP - base);
        rd_reg(8'h10, v); chk("R4 wrap to zero", v, 32'h0);
        step(5);
        rd_reg(8'h10, v); chk("R4 after wrap", v, 32'h5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule